// File: doc/BRIEF.md
# Video-Mode Line and Frame Timing Generator

This block paces the video-mode transmission of a serial display link. It counts in lane byte clock cycles along each line and in lines down each frame. It emits strobes for the start of each line's sync, for the end of the sync pulse, for blanking, for the active-pixel window and for the end of each frame. A packet builder downstream uses these strobes to decide what to send and when. A single flag tells the link layer whether the current region may fall back to low power.

Horizontal timing is given in byte-clock cycles: the sync-active time, the back-porch time, the active time and the total line time. Software converts each pixel count by rounding up pixels × lane rate / 8 / pixel clock. The front porch is whatever is left of the line. Vertical timing is given in lines: sync, back porch, active and front porch, and a frame runs through them in that order. A 2-bit mode type picks one of three cases: sync pulses, sync events, or burst. A 6-bit mask picks the regions that may enter low power. The block captures all timing inputs when it is enabled and again at every frame boundary, so a change made mid-frame has no effect until the next frame begins.

Top module: `dsi_vid_timing`

## Requirements
- R1: After reset, and from the first clock edge that samples `en_i` low, every output is 0. A later enable restarts counting at the first cycle of line 0.
- R2: Each line lasts `hline_i` cycles. `sync_start_o` is high for exactly the first cycle of every line.
- R3: With mode 0 (sync pulses), `sync_end_o` pulses on the cycle `hsa_i` cycles after the line starts. With mode 1 (sync events), 2 (burst) or the unused code 3, `sync_end_o` stays 0.
- R4: `active_o` is high for `hact_i` cycles, starting `hsa_i + hbp_i` cycles into the line. This happens only on lines `vsa_i + vbp_i` through `vsa_i + vbp_i + vact_i - 1` of the frame.
- R5: Lines run in this order: sync, back porch, active, front porch. `frame_end_o` pulses on the last cycle of line `vsa_i + vbp_i + vact_i + vfp_i - 1`, and the next cycle is line 0, cycle 0.
- R6: While running, `blank_o` is the inverse of `active_o`.
- R7: On vertical sync, back-porch and front-porch lines, `lp_ok_o` equals mask bit 0, 1 and 2 respectively. The exception is the first `hsa_i` cycles of a line in mode 0, where it is 0.
- R8: On active lines, `lp_ok_o` is 0 inside the pixel window. Before the window it is mask bit 3 AND bit 4, except that the first `hsa_i` cycles in mode 0 give 0. After the window it is mask bit 3 AND bit 5.
- R9: Timing, mode and mask inputs changed during a running frame have no effect until the first cycle of the following frame.
- R10: The timing inputs present at the enabling clock edge govern the first frame after enable.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Lane byte clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Run enable |
| mode_i | input | 2 | Mode type: 0 sync pulses, 1 sync events, 2 burst |
| lp_mask_i | input | 6 | Low-power region mask |
| hsa_i | input | HW | Horizontal sync-active time, byte clocks |
| hbp_i | input | HW | Horizontal back-porch time, byte clocks |
| hact_i | input | HW | Horizontal active time, byte clocks |
| hline_i | input | HW | Total line time, byte clocks |
| vsa_i | input | VW | Vertical sync lines |
| vbp_i | input | VW | Vertical back-porch lines |
| vact_i | input | VW | Active lines |
| vfp_i | input | VW | Vertical front-porch lines |
| sync_start_o | output | 1 | First cycle of each line |
| sync_end_o | output | 1 | End of horizontal sync pulse (mode 0) |
| blank_o | output | 1 | Outside the active-pixel window |
| active_o | output | 1 | Active-pixel window |
| frame_end_o | output | 1 | Last cycle of the frame |
| lp_ok_o | output | 1 | Current region may use low power |

## Verification
All outputs decode registered counters and the captured configuration with combinational logic. So when enable is raised at one clock edge, frame cycle 0 is visible in the next clock period, and each further edge moves it one cycle along. A falling enable shows as all-zero outputs one edge later. Inputs change on falling edges and outputs are sampled on falling edges. The bench keeps its own cycle index from the enabling edge and derives line and column from it. Each sample is therefore compared against the exact frame cycle the design should be in, including the wrap into the next frame and the frame in which a mid-frame configuration change first applies.

// File: rtl/dsi_vtg_pkg.sv
package dsi_vtg_pkg;
  typedef enum logic [1:0] {HR_SYNC, HR_BACK, HR_ACT, HR_FRONT} h_region_e;
  typedef enum logic [1:0] {VR_SYNC, VR_BACK, VR_ACT, VR_FRONT} v_region_e;
  typedef enum logic [1:0] {
    MODE_SYNC_PULSE = 2'd0,
    MODE_SYNC_EVENT = 2'd1,
    MODE_BURST      = 2'd2
  } vid_mode_e;

  localparam int LP_W    = 6;
  localparam int LP_VSA  = 0;
  localparam int LP_VBP  = 1;
  localparam int LP_VFP  = 2;
  localparam int LP_VACT = 3;
  localparam int LP_HBP  = 4;
  localparam int LP_HFP  = 5;
endpackage

// File: rtl/vtg_cfg_reg.sv
module vtg_cfg_reg #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q_o <= '0;
    else if (load_i) q_o <= d_i;
  end
endmodule

// File: rtl/vtg_hcount.sv
module vtg_hcount
  import dsi_vtg_pkg::*;
#(
  parameter int HW = 12
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          adv_i,
  input  logic [HW-1:0] hsa_i,
  input  logic [HW-1:0] hbp_i,
  input  logic [HW-1:0] hact_i,
  input  logic [HW-1:0] hline_i,
  output logic [HW-1:0] cnt_o,
  output logic          line_end_o,
  output h_region_e     region_o
);
  localparam int SW = HW + 2;

  logic [SW-1:0] bnd_sync, bnd_back, bnd_act, cnt_w;

  assign bnd_sync   = SW'(hsa_i);
  assign bnd_back   = bnd_sync + SW'(hbp_i);
  assign bnd_act    = bnd_back + SW'(hact_i);
  assign cnt_w      = SW'(cnt_o);
  assign line_end_o = (cnt_o == hline_i - 1'b1);

  always_comb begin
    if (cnt_w < bnd_sync)      region_o = HR_SYNC;
    else if (cnt_w < bnd_back) region_o = HR_BACK;
    else if (cnt_w < bnd_act)  region_o = HR_ACT;
    else                       region_o = HR_FRONT;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cnt_o <= '0;
    else if (!adv_i)    cnt_o <= '0;
    else if (line_end_o) cnt_o <= '0;
    else                cnt_o <= cnt_o + 1'b1;
  end

  AST_HCNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv_i |-> (cnt_o < hline_i)); // R2
  AST_LINE_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && line_end_o) |=> (cnt_o == '0)); // R2
endmodule

// File: rtl/vtg_vcount.sv
module vtg_vcount
  import dsi_vtg_pkg::*;
#(
  parameter int VW = 11
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            clr_i,
  input  logic            step_i,
  input  logic [VW-1:0]   vsa_i,
  input  logic [VW-1:0]   vbp_i,
  input  logic [VW-1:0]   vact_i,
  input  logic [VW-1:0]   vfp_i,
  output logic [VW+1:0]   cnt_o,
  output logic            last_line_o,
  output v_region_e       region_o
);
  localparam int SW = VW + 2;

  logic [SW-1:0] bnd_sync, bnd_back, bnd_act, total;

  assign bnd_sync    = SW'(vsa_i);
  assign bnd_back    = bnd_sync + SW'(vbp_i);
  assign bnd_act     = bnd_back + SW'(vact_i);
  assign total       = bnd_act + SW'(vfp_i);
  assign last_line_o = (cnt_o == total - 1'b1);

  always_comb begin
    if (cnt_o < bnd_sync)      region_o = VR_SYNC;
    else if (cnt_o < bnd_back) region_o = VR_BACK;
    else if (cnt_o < bnd_act)  region_o = VR_ACT;
    else                       region_o = VR_FRONT;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_o <= '0;
    else if (clr_i)       cnt_o <= '0;
    else if (step_i)      cnt_o <= last_line_o ? '0 : cnt_o + 1'b1;
  end

  AST_VCNT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !step_i) |=> $stable(cnt_o)); // R5
endmodule

// File: rtl/dsi_vid_timing.sv
module dsi_vid_timing
  import dsi_vtg_pkg::*;
#(
  parameter int HW = 12,
  parameter int VW = 11
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            en_i,
  input  logic [1:0]      mode_i,
  input  logic [LP_W-1:0] lp_mask_i,
  input  logic [HW-1:0]   hsa_i,
  input  logic [HW-1:0]   hbp_i,
  input  logic [HW-1:0]   hact_i,
  input  logic [HW-1:0]   hline_i,
  input  logic [VW-1:0]   vsa_i,
  input  logic [VW-1:0]   vbp_i,
  input  logic [VW-1:0]   vact_i,
  input  logic [VW-1:0]   vfp_i,
  output logic            sync_start_o,
  output logic            sync_end_o,
  output logic            blank_o,
  output logic            active_o,
  output logic            frame_end_o,
  output logic            lp_ok_o
);
  localparam int CFG_W = 2 + LP_W + 4 * HW + 4 * VW;

  logic              run_q, adv, line_end, last_line, frame_last, load;
  logic [CFG_W-1:0]  cfg_d, cfg_s;
  logic [1:0]        mode_s;
  logic [LP_W-1:0]   mask_s;
  logic [HW-1:0]     hsa_s, hbp_s, hact_s, hline_s, h_cnt;
  logic [VW-1:0]     vsa_s, vbp_s, vact_s, vfp_s;
  logic [VW+1:0]     v_cnt;
  h_region_e         h_reg;
  v_region_e         v_reg;
  logic              pulse_hsa, lp_raw;

  assign cfg_d = {mode_i, lp_mask_i, hsa_i, hbp_i, hact_i, hline_i,
                  vsa_i, vbp_i, vact_i, vfp_i};
  assign {mode_s, mask_s, hsa_s, hbp_s, hact_s, hline_s,
          vsa_s, vbp_s, vact_s, vfp_s} = cfg_s;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) run_q <= 1'b0;
    else         run_q <= en_i;
  end

  assign adv        = run_q & en_i;
  assign frame_last = line_end & last_line;
  // capture on the enabling edge and at every frame wrap
  assign load       = en_i & (~run_q | frame_last);

  vtg_cfg_reg #(.W(CFG_W)) u_cfg (
    .clk_i, .rst_ni, .load_i(load), .d_i(cfg_d), .q_o(cfg_s)
  );

  vtg_hcount #(.HW(HW)) u_h (
    .clk_i, .rst_ni, .adv_i(adv),
    .hsa_i(hsa_s), .hbp_i(hbp_s), .hact_i(hact_s), .hline_i(hline_s),
    .cnt_o(h_cnt), .line_end_o(line_end), .region_o(h_reg)
  );

  vtg_vcount #(.VW(VW)) u_v (
    .clk_i, .rst_ni, .clr_i(~adv), .step_i(line_end),
    .vsa_i(vsa_s), .vbp_i(vbp_s), .vact_i(vact_s), .vfp_i(vfp_s),
    .cnt_o(v_cnt), .last_line_o(last_line), .region_o(v_reg)
  );

  assign pulse_hsa = (mode_s == MODE_SYNC_PULSE) && (h_reg == HR_SYNC);

  always_comb begin
    lp_raw = 1'b0;
    if (!pulse_hsa) begin
      unique case (v_reg)
        VR_SYNC:  lp_raw = mask_s[LP_VSA];
        VR_BACK:  lp_raw = mask_s[LP_VBP];
        VR_FRONT: lp_raw = mask_s[LP_VFP];
        VR_ACT: begin
          unique case (h_reg)
            HR_SYNC, HR_BACK: lp_raw = mask_s[LP_VACT] & mask_s[LP_HBP];
            HR_FRONT:         lp_raw = mask_s[LP_VACT] & mask_s[LP_HFP];
            default:          lp_raw = 1'b0;
          endcase
        end
        default: lp_raw = 1'b0;
      endcase
    end
  end

  assign sync_start_o = run_q && (h_cnt == '0);
  assign sync_end_o   = run_q && (mode_s == MODE_SYNC_PULSE) && (h_cnt == hsa_s);
  assign active_o     = run_q && (v_reg == VR_ACT) && (h_reg == HR_ACT);
  assign blank_o      = run_q && !active_o;
  assign frame_end_o  = run_q && frame_last;
  assign lp_ok_o      = run_q && lp_raw;

  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_q |-> !(sync_start_o | sync_end_o | blank_o | active_o | frame_end_o | lp_ok_o)); // R1
  AST_SYNC_END_MODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_end_o |-> (mode_s == 2'd0)); // R3
  AST_FRAME_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_end_o && en_i) |=> (sync_start_o && v_cnt == '0)); // R5
  AST_ACT_NOT_LP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_o |-> !lp_ok_o); // R8
  AST_CFG_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && en_i && !frame_last) |=> $stable(cfg_s)); // R9
endmodule

// File: tb/dsi_vid_timing_test.sv
`timescale 1ns/1ps
module dsi_vid_timing_test;
  typedef struct packed {
    logic [1:0] mode;
    logic [5:0] mask;
    logic [7:0] hsa, hbp, hact, hline, vsa, vbp, vact, vfp;
  } vec_t;

  localparam int NV = 5;
  localparam vec_t VEC [NV] = '{
    '{2'd0, 6'b111111, 8'd2, 8'd3, 8'd8,  8'd16, 8'd1, 8'd2, 8'd3, 8'd2},
    '{2'd1, 6'b010101, 8'd3, 8'd2, 8'd6,  8'd14, 8'd2, 8'd1, 8'd2, 8'd1},
    '{2'd2, 6'b101010, 8'd1, 8'd1, 8'd10, 8'd15, 8'd1, 8'd1, 8'd4, 8'd1},
    '{2'd0, 6'b011000, 8'd4, 8'd2, 8'd5,  8'd11, 8'd1, 8'd1, 8'd2, 8'd2},
    '{2'd3, 6'b100111, 8'd2, 8'd2, 8'd4,  8'd12, 8'd3, 8'd2, 8'd1, 8'd2}
  };

  logic clk = 1'b0, rst_ni = 1'b0, en = 1'b0;
  logic [1:0]  mode;
  logic [5:0]  mask;
  logic [11:0] hsa, hbp, hact, hline;
  logic [10:0] vsa, vbp, vact, vfp;
  logic ss, se, bl, ac, fe, lp;
  int total = 0, bad = 0;

  always #2.5 clk = ~clk;

  dsi_vid_timing uut (
    .clk_i(clk), .rst_ni(rst_ni), .en_i(en), .mode_i(mode), .lp_mask_i(mask),
    .hsa_i(hsa), .hbp_i(hbp), .hact_i(hact), .hline_i(hline),
    .vsa_i(vsa), .vbp_i(vbp), .vact_i(vact), .vfp_i(vfp),
    .sync_start_o(ss), .sync_end_o(se), .blank_o(bl), .active_o(ac),
    .frame_end_o(fe), .lp_ok_o(lp)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0b exp=%0b t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic drive(input vec_t c);
    mode = c.mode; mask = c.mask;
    hsa = 12'(c.hsa); hbp = 12'(c.hbp); hact = 12'(c.hact); hline = 12'(c.hline);
    vsa = 11'(c.vsa); vbp = 11'(c.vbp); vact = 11'(c.vact); vfp = 11'(c.vfp);
  endtask

  task automatic chk_idle(input string pre);
    chk({pre, "R1 sync_start idle"}, ss, 1'b0);
    chk({pre, "R1 sync_end idle"}, se, 1'b0);
    chk({pre, "R1 blank idle"}, bl, 1'b0);
    chk({pre, "R1 active idle"}, ac, 1'b0);
    chk({pre, "R1 frame_end idle"}, fe, 1'b0);
    chk({pre, "R1 lp_ok idle"}, lp, 1'b0);
  endtask

  // walk one frame from cycle 0; optional input change or early stop
  task automatic run_frame(input vec_t c, input string pre, input int chg_at,
                           input vec_t nxt, input int stop);
    int hl, nl, len, a0, a1;
    hl  = int'(c.hline);
    nl  = int'(c.vsa) + int'(c.vbp) + int'(c.vact) + int'(c.vfp);
    len = hl * nl;
    a0  = int'(c.vsa) + int'(c.vbp);
    a1  = a0 + int'(c.vact);
    for (int k = 0; k < ((stop < 0) ? len : stop); k++) begin
      int h, v;
      logic e_act, e_lp, pulse;
      @(negedge clk);
      h = k % hl;
      v = k / hl;
      pulse = (c.mode == 2'd0) && (h < int'(c.hsa));
      e_act = (v >= a0) && (v < a1) && (h >= int'(c.hsa) + int'(c.hbp)) &&
              (h < int'(c.hsa) + int'(c.hbp) + int'(c.hact));
      if (v >= a0 && v < a1) begin
        if (e_act || pulse) e_lp = 1'b0;
        else if (h < int'(c.hsa) + int'(c.hbp)) e_lp = c.mask[3] & c.mask[4];
        else e_lp = c.mask[3] & c.mask[5];
        chk({pre, "R8 lp_ok active line"}, lp, e_lp);
      end else begin
        if (pulse) e_lp = 1'b0;
        else if (v < int'(c.vsa)) e_lp = c.mask[0];
        else if (v < a0) e_lp = c.mask[1];
        else e_lp = c.mask[2];
        chk({pre, "R7 lp_ok blank line"}, lp, e_lp);
      end
      chk({pre, "R2 sync_start"}, ss, h == 0);
      chk({pre, "R3 sync_end"}, se, (c.mode == 2'd0) && (h == int'(c.hsa)));
      chk({pre, "R4 active"}, ac, e_act);
      chk({pre, "R6 blank"}, bl, !e_act);
      chk({pre, "R5 frame_end"}, fe, k == len - 1);
      if (k == chg_at) drive(nxt);
    end
  endtask

  initial begin
    #1ms;
    bad++;
    $display("FAIL watchdog expired act=running exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    drive(VEC[0]);
    repeat (3) @(negedge clk);
    chk_idle("reset ");
    rst_ni = 1'b1;
    @(negedge clk);
    chk_idle("post-reset ");

    // table walk: two frames per vector, captured at enable (R10)
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      en = 1'b0;
      drive(VEC[i]);
      @(negedge clk);
      chk_idle("disabled ");
      en = 1'b1;
      run_frame(VEC[i], "R10 ", -1, VEC[i], -1);
      run_frame(VEC[i], "wrap ", -1, VEC[i], -1);
    end

    // mid-frame change is deferred to the next frame (R9)
    @(negedge clk);
    en = 1'b0;
    drive(VEC[0]);
    @(negedge clk);
    en = 1'b1;
    run_frame(VEC[0], "R9 old ", 5, VEC[1], -1);
    run_frame(VEC[1], "R9 new ", -1, VEC[1], -1);

    // disable mid-frame, reconfigure, restart at cycle 0 (R1, R10)
    run_frame(VEC[1], "pre-stop ", -1, VEC[1], 7);
    en = 1'b0;
    @(negedge clk);
    chk_idle("stop ");
    drive(VEC[2]);
    en = 1'b1;
    run_frame(VEC[2], "R10 restart ", -1, VEC[2], -1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule